// File: doc/BRIEF.md
# Data Cache Store Write Policy Controller

This block decides how a data cache handles each cacheable store. Software programs a small control register with a global write-mode bit and a two-bit allocation policy. For every store the cache presents, the block combines that register with the lookup result (hit or miss), the page write-through attribute from translation, and a flag saying whether a line refill is in flight. From these it returns three decisions in the same cycle: whether the store is write-through or copy-back, whether a miss should allocate a line, and whether the store data should be merged into the pending refill buffer.

The same register holds two sticky status flags. One records that a snoop invalidation removed a locked line. The other records that a lock-set request failed for a reason other than running out of lock capacity. Hardware sets each flag with a single-cycle pulse. Each flag stays set until software writes a zero to its bit. The arrays, translation, bus and snoop logic sit outside this block and deliver their events as single-cycle pulses.

Register layout, `cfg_wdata`/`cfg_rdata`: bit 0 is the copy-back enable. Bits 2:1 are the allocation policy: 00 none, 01 copy-back misses only, 10 all misses, 11 reserved. Bit 3 is the snoop-removed-lock flag. Bit 4 is the lock-failed flag. Bits 7:5 are reserved.

Top module: `wpol_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads all zeros, so the block starts in write-through mode with no allocation.
- R2: With bit 0 at 0, every valid store reports `dec_wt`=1, whatever `page_wt` is.
- R3: With bit 0 at 1, a valid store reports `dec_wt` equal to `page_wt`.
- R4: With the allocation policy 00, `dec_alloc` is never asserted.
- R5: With the allocation policy 01, `dec_alloc` is asserted only for a valid store miss whose `dec_wt` is 0.
- R6: With the allocation policy 10, `dec_alloc` is asserted for every valid store miss. No store hit ever allocates.
- R7: The reserved allocation policy 11 behaves as 00: no allocation and no merging.
- R8: `dec_merge` is asserted exactly when a store is valid, `fill_busy` is 1, and the allocation policy is 01 or 10. The write type does not affect it.
- R9: A `snoop_lock_inval` pulse sets bit 3 from the next cycle on. The bit stays set until a register write carries 0 in bit 3. Writing 1 to it has no effect.
- R10: A `lock_fail` pulse with `lock_ovf`=0 sets bit 4 in the same sticky way. A pulse with `lock_ovf`=1 leaves bit 4 unchanged.
- R11: When a set pulse and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R12: A register write changes the mode and policy from the next cycle on. Bits 7:5 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| st_valid | input | 1 | A cacheable store is presented |
| st_miss | input | 1 | The store missed in the cache |
| page_wt | input | 1 | Page write-through attribute |
| fill_busy | input | 1 | A line refill is in progress |
| snoop_lock_inval | input | 1 | Pulse: a snoop invalidated a locked line |
| lock_fail | input | 1 | Pulse: a lock-set request failed |
| lock_ovf | input | 1 | Qualifies `lock_fail` as a lock overflow |
| dec_wt | output | 1 | Store is write-through (0: copy-back) |
| dec_alloc | output | 1 | Miss allocates a line |
| dec_merge | output | 1 | Store data merges into the refill buffer |

## Verification
Assertions check several things on every cycle: forced write-through in mode 0, allocation only on valid misses and never under policy 00 or 11, merging only during a refill, the setting and holding of both flags, overflow suppression, set-over-clear priority, and reserved bits reading zero. Other behaviour needs the bench's own model over random and directed traffic. That covers the exact copy-back/write-through split under policy 01 and the fact that a write of 1 leaves a flag unchanged. It also covers the one-cycle delay before a register write takes effect, and that merging ignores the write type.

// File: rtl/wpol_pkg.sv
package wpol_pkg;

    localparam int CFG_W     = 8;
    localparam int CB_BIT    = 0;
    localparam int ALLOC_LSB = 1;
    localparam int SNP_BIT   = 3;
    localparam int ULK_BIT   = 4;
    localparam int USED_W    = 5;

    typedef enum logic [1:0] {
        ALLOC_NONE = 2'b00,
        ALLOC_CB   = 2'b01,
        ALLOC_ALL  = 2'b10,
        ALLOC_RSVD = 2'b11
    } alloc_e;

    typedef struct packed {
        logic   lock_failed;
        logic   snoop_lost;
        alloc_e alloc;
        logic   copyback;
    } ctl_t;

endpackage

// File: rtl/wpol_ctl_reg.sv
module wpol_ctl_reg
    import wpol_pkg::*;
#(
    parameter int REG_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             snp_evt,
    input  logic             lkf_evt,
    input  logic             lkf_ovf,
    output ctl_t             ctl_q,
    output logic [REG_W-1:0] rd_data
);

    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.copyback = wr_data[CB_BIT];
            ctl_d.alloc    = alloc_e'(wr_data[ALLOC_LSB +: 2]);
            if (!wr_data[SNP_BIT]) ctl_d.snoop_lost  = 1'b0;
            if (!wr_data[ULK_BIT]) ctl_d.lock_failed = 1'b0;
        end
        // hardware set has priority over software clear
        if (snp_evt)             ctl_d.snoop_lost  = 1'b1;
        if (lkf_evt && !lkf_ovf) ctl_d.lock_failed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data = '0;
        rd_data[CB_BIT]            = ctl_q.copyback;
        rd_data[ALLOC_LSB +: 2]    = ctl_q.alloc;
        rd_data[SNP_BIT]           = ctl_q.snoop_lost;
        rd_data[ULK_BIT]           = ctl_q.lock_failed;
    end

    assert_snoop_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_evt |=> ctl_q.snoop_lost);

    assert_snoop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.snoop_lost && !(wr_en && !wr_data[SNP_BIT])) |=> ctl_q.snoop_lost);

    assert_lockfail_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lkf_evt && !lkf_ovf) |=> ctl_q.lock_failed);

    assert_lockfail_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lkf_evt && lkf_ovf && !ctl_q.lock_failed && !snp_evt && !wr_en) |=> !ctl_q.lock_failed);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lkf_evt && !lkf_ovf && wr_en && !wr_data[ULK_BIT]) |=> ctl_q.lock_failed);

    assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data >> USED_W) == '0);

endmodule

// File: rtl/wpol_decide.sv
module wpol_decide
    import wpol_pkg::*;
(
    input  ctl_t ctl,
    input  logic st_valid,
    input  logic st_miss,
    input  logic page_wt,
    input  logic fill_busy,
    output logic wt,
    output logic alloc,
    output logic merge
);

    logic policy_on;
    logic alloc_ok;

    always_comb begin
        wt        = !ctl.copyback || page_wt;
        policy_on = (ctl.alloc == ALLOC_CB) || (ctl.alloc == ALLOC_ALL);
        unique case (ctl.alloc)
            ALLOC_CB:  alloc_ok = !wt;
            ALLOC_ALL: alloc_ok = 1'b1;
            default:   alloc_ok = 1'b0;
        endcase
        alloc = st_valid && st_miss && alloc_ok;
        merge = st_valid && fill_busy && policy_on;
    end

endmodule

// File: rtl/wpol_ctrl.sv
module wpol_ctrl
    import wpol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             st_valid,
    input  logic             st_miss,
    input  logic             page_wt,
    input  logic             fill_busy,
    input  logic             snoop_lock_inval,
    input  logic             lock_fail,
    input  logic             lock_ovf,
    output logic             dec_wt,
    output logic             dec_alloc,
    output logic             dec_merge
);

    ctl_t ctl_q;

    wpol_ctl_reg #(.REG_W(CFG_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .snp_evt (snoop_lock_inval),
        .lkf_evt (lock_fail),
        .lkf_ovf (lock_ovf),
        .ctl_q   (ctl_q),
        .rd_data (cfg_rdata)
    );

    wpol_decide u_dec (
        .ctl       (ctl_q),
        .st_valid  (st_valid),
        .st_miss   (st_miss),
        .page_wt   (page_wt),
        .fill_busy (fill_busy),
        .wt        (dec_wt),
        .alloc     (dec_alloc),
        .merge     (dec_merge)
    );

    assert_wt_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !cfg_rdata[CB_BIT]) |-> dec_wt);

    assert_alloc_none_R4_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[ALLOC_LSB +: 2] == 2'b00 || cfg_rdata[ALLOC_LSB +: 2] == 2'b11)
            |-> !dec_alloc && !dec_merge);

    assert_alloc_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_alloc |-> (st_valid && st_miss));

    assert_merge_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_merge |-> (st_valid && fill_busy));

endmodule

// File: tb/wpol_ctrl_tb.sv
module wpol_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       st_valid = 1'b0, st_miss = 1'b0, page_wt = 1'b0, fill_busy = 1'b0;
    logic       snoop_lock_inval = 1'b0, lock_fail = 1'b0, lock_ovf = 1'b0;
    logic       dec_wt, dec_alloc, dec_merge;

    int checks = 0;
    int fails  = 0;

    logic       m_cb = 1'b0;
    logic [1:0] m_al = 2'b00;
    logic       m_snp = 1'b0, m_ulk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpol_ctrl u_dut (.*);

    function automatic logic exp_wt(input logic cb, input logic pw);
        return !cb || pw;
    endfunction

    function automatic logic exp_alloc(input logic [1:0] al, input logic cb,
                                       input logic v, input logic miss, input logic pw);
        if (!(v && miss)) return 1'b0;
        if (al == 2'b01) return !exp_wt(cb, pw);
        if (al == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_merge(input logic [1:0] al, input logic v, input logic fb);
        return v && fb && (al == 2'b01 || al == 2'b10);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // inputs are already driven; check outputs mid-cycle, then advance the model at the edge
    task automatic step();
        #1;
        chk("R12 R9 R10 R11 cfg_rdata", cfg_rdata, {3'b000, m_ulk, m_snp, m_al, m_cb});
        if (st_valid) chk("R2 R3 dec_wt", {7'b0, dec_wt}, {7'b0, exp_wt(m_cb, page_wt)});
        chk("R4 R5 R6 R7 dec_alloc", {7'b0, dec_alloc},
            {7'b0, exp_alloc(m_al, m_cb, st_valid, st_miss, page_wt)});
        chk("R8 dec_merge", {7'b0, dec_merge}, {7'b0, exp_merge(m_al, st_valid, fill_busy)});
        @(posedge clk);
        if (cfg_we) begin
            m_cb = cfg_wdata[0];
            m_al = cfg_wdata[2:1];
            if (!cfg_wdata[3]) m_snp = 1'b0;
            if (!cfg_wdata[4]) m_ulk = 1'b0;
        end
        if (snoop_lock_inval)       m_snp = 1'b1;
        if (lock_fail && !lock_ovf) m_ulk = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; snoop_lock_inval = 1'b0; lock_fail = 1'b0; lock_ovf = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        chk("R1 reset value", cfg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: write-through, no allocation out of reset
        st_valid = 1; st_miss = 1; page_wt = 0; fill_busy = 1;
        step();

        // R12: write takes effect next cycle; reserved bits read zero
        wr(8'hE3);                 // copyback, policy 01, reserved ones
        chk("R12 write applied", cfg_rdata, 8'h03);
        // R5: copy-back miss allocates, write-through miss does not
        page_wt = 0; step();
        page_wt = 1; step();
        // R6 policy 10
        wr(8'h05);
        for (int i = 0; i < 4; i++) begin
            st_miss = i[0]; page_wt = i[1]; step();
        end
        // R7 reserved policy
        wr(8'h07);
        fill_busy = 1; st_miss = 1; step();
        // R9: set, hold, write-one no effect, clear
        snoop_lock_inval = 1; step();
        chk("R9 flag set", {7'b0, cfg_rdata[3]}, 8'h01);
        wr(8'h0F); step();
        chk("R9 write 1 no effect", {7'b0, cfg_rdata[3]}, 8'h01);
        wr(8'h07);
        chk("R9 cleared", {7'b0, cfg_rdata[3]}, 8'h00);
        // R10: overflow suppressed, then real failure sets
        lock_fail = 1; lock_ovf = 1; step();
        chk("R10 overflow ignored", {7'b0, cfg_rdata[4]}, 8'h00);
        lock_fail = 1; step();
        chk("R10 flag set", {7'b0, cfg_rdata[4]}, 8'h01);
        // R11: set and clear in the same cycle
        lock_fail = 1; snoop_lock_inval = 1; cfg_we = 1; cfg_wdata = 8'h00; step();
        chk("R11 set wins", cfg_rdata, 8'h18);

        for (int n = 0; n < 3000; n++) begin
            st_valid  = $urandom_range(0, 3) != 0;
            st_miss   = $urandom_range(0, 1);
            page_wt   = $urandom_range(0, 1);
            fill_busy = $urandom_range(0, 1);
            snoop_lock_inval = $urandom_range(0, 9) == 0;
            lock_fail = $urandom_range(0, 9) == 0;
            lock_ovf  = $urandom_range(0, 1);
            cfg_we    = $urandom_range(0, 7) == 0;
            cfg_wdata = 8'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule